// File: doc/BRIEF.md
# Binary to Canonic Signed-Digit Converter

This block recodes an unsigned binary word of `WIDTH` bits into canonic signed-digit (CSD) form. The result has `WIDTH+1` digits, and each digit is -1, 0 or +1. The recoding is the unique signed-digit form in which no two neighbouring digits are both nonzero. This form also has the fewest nonzero digits of any signed-digit form of the same value. Constant-coefficient multipliers and filter generators use it to cut the number of partial-product additions.

A ripple of identical cells computes the digits, working upward from the least significant position. Each cell passes a carry to the cell above it. Every digit leaves the block as two bits, a sign bit and a data bit, and the digit's value is data minus sign. A separate adder counts the nonzero digits. A word presented with `in_valid` is converted within the same cycle and captured in an output register, so its result appears one cycle later. The output register holds its contents while no new word is presented.

Top module: `csd_converter`

## Requirements
- R1: For every accepted word, the sum over all digit positions i of (out_data[i] − out_sign[i])·2^i equals the unsigned input value.
- R2: No two neighbouring digits are both nonzero. For every i, digit i and digit i+1 are never both nonzero.
- R3: The number of nonzero digits is the minimum over all signed-digit representations of the input.
- R4: The digit vector equals the unique canonical recoding. For example, 124 gives +1 at position 7 and −1 at position 2; 123 gives +1 at position 7 and −1 at positions 2 and 0.
- R5: Digit encoding is {sign, data}: +1 is sign=0, data=1; −1 is sign=1, data=0; zero is always sign=0, data=0. The redundant zero code sign=1, data=1 is never produced.
- R6: `out_nonzero` equals the number of nonzero digits in the registered result.
- R7: `out_valid` is `in_valid` delayed by one clock. When `in_valid` is low, the digit and count outputs keep their previous values whatever `in_word` carries.
- R8: While `rst` is high at a clock edge, all outputs are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks `in_word` as a word to convert |
| in_word | input | WIDTH | Unsigned binary input |
| out_valid | output | 1 | Result registers hold a fresh conversion |
| out_sign | output | WIDTH+1 | Sign bit of each digit |
| out_data | output | WIDTH+1 | Data bit of each digit |
| out_nonzero | output | $clog2(WIDTH+2) | Count of nonzero digits |

## Verification
The bench sweeps all 65536 inputs of the 16-bit configuration and compares each result with a recoding it computes by integer modular arithmetic. Long runs of ones test whether the carry chain propagates correctly. Such an input, for example 0xFFFF, must produce a single +1 in the extra top digit and −1 at position 0. A design that dropped that top digit or mishandled the last bit would produce a value that is wrong or off by one. Isolated ones next to runs, such as 0b1011, test the look-ahead on the next input bit. A design that ignored that bit would either produce neighbouring nonzero digits or use more nonzero digits than the minimum. A further step changes `in_word` while `in_valid` is low and confirms that the registered result does not change.

// File: rtl/csd_pkg.sv
package csd_pkg;

    // Digit code laid out as {sign, data}; value = data - sign.
    typedef enum logic [1:0] {
        CSD_ZERO = 2'b00,
        CSD_POS  = 2'b01,
        CSD_NEG  = 2'b10,
        CSD_ZALT = 2'b11
    } csd_code_e;

    typedef struct packed {
        csd_code_e code;
        logic      carry;
    } csd_step_t;

    // One recursion step: t = x_cur + c_in, with a look at the next input bit.
    function automatic csd_step_t csd_step(input logic x_cur,
                                           input logic x_nxt,
                                           input logic c_in);
        csd_step_t r;
        if (x_cur ^ c_in) begin
            if (x_nxt) begin
                r.code  = CSD_NEG;
                r.carry = 1'b1;
            end else begin
                r.code  = CSD_POS;
                r.carry = 1'b0;
            end
        end else begin
            r.code  = CSD_ZERO;
            r.carry = x_cur & c_in;
        end
        return r;
    endfunction

endpackage

// File: rtl/csd_digit_cell.sv
module csd_digit_cell
    import csd_pkg::*;
(
    input  logic x_cur,
    input  logic x_nxt,
    input  logic c_in,
    output logic dig_sign,
    output logic dig_data,
    output logic c_out
);
    csd_step_t st;

    always_comb begin
        st       = csd_step(x_cur, x_nxt, c_in);
        dig_sign = st.code[1];
        dig_data = st.code[0];
        c_out    = st.carry;
    end

    // A cell never emits the redundant zero code.
    always_comb begin
        AST_CELL_NO_ALT_ZERO: assert (!(dig_sign && dig_data)); // R5
    end
endmodule

// File: rtl/csd_chain.sv
module csd_chain #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] in_word,
    output logic [WIDTH:0]   sign_vec,
    output logic [WIDTH:0]   data_vec
);
    localparam int DIGITS = WIDTH + 1;

    logic [WIDTH:0]   x_ext;
    logic [WIDTH:0]   carry;
    logic [WIDTH-1:0] s_low;
    logic [WIDTH-1:0] d_low;
    logic [WIDTH:0]   nz_vec;

    assign x_ext    = {1'b0, in_word};
    assign carry[0] = 1'b0;

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        csd_digit_cell u_cell (
            .x_cur   (x_ext[i]),
            .x_nxt   (x_ext[i+1]),
            .c_in    (carry[i]),
            .dig_sign(s_low[i]),
            .dig_data(d_low[i]),
            .c_out   (carry[i+1])
        );
    end

    // Top digit: the leftover carry is always a positive one.
    assign sign_vec = {1'b0, s_low};
    assign data_vec = {carry[WIDTH], d_low};
    assign nz_vec   = sign_vec ^ data_vec;

    always_comb begin
        AST_CHAIN_NO_ADJACENT: assert ((nz_vec & (nz_vec >> 1)) == '0); // R2
        AST_CHAIN_VALUE: assert ((data_vec - sign_vec) == DIGITS'(x_ext)); // R1
    end
endmodule

// File: rtl/csd_weight.sv
module csd_weight #(
    parameter int N     = 17,
    parameter int CNT_W = $clog2(N + 1)
) (
    input  logic [N-1:0]     nz,
    output logic [CNT_W-1:0] count
);
    always_comb begin
        count = '0;
        for (int i = 0; i < N; i++) begin
            count = count + CNT_W'(nz[i]);
        end
    end
endmodule

// File: rtl/csd_converter.sv
module csd_converter #(
    parameter int WIDTH = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic [WIDTH-1:0]           in_word,
    output logic                       out_valid,
    output logic [WIDTH:0]             out_sign,
    output logic [WIDTH:0]             out_data,
    output logic [$clog2(WIDTH+2)-1:0] out_nonzero
);
    localparam int DIGITS = WIDTH + 1;
    localparam int CNT_W  = $clog2(DIGITS + 1);

    logic [WIDTH:0]   comb_sign;
    logic [WIDTH:0]   comb_data;
    logic [CNT_W-1:0] comb_count;

    csd_chain #(.WIDTH(WIDTH)) u_chain (
        .in_word (in_word),
        .sign_vec(comb_sign),
        .data_vec(comb_data)
    );

    csd_weight #(.N(DIGITS), .CNT_W(CNT_W)) u_weight (
        .nz   (comb_sign ^ comb_data),
        .count(comb_count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_sign    <= '0;
            out_data    <= '0;
            out_nonzero <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_sign    <= comb_sign;
                out_data    <= comb_data;
                out_nonzero <= comb_count;
            end
        end
    end

    AST_OUT_VALUE: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ((out_data - out_sign) == DIGITS'({1'b0, $past(in_word)}))); // R1
    AST_OUT_NO_ADJACENT: assert property (@(posedge clk) disable iff (rst)
        (((out_sign ^ out_data) & ((out_sign ^ out_data) >> 1)) == '0)); // R2
    AST_OUT_NO_ALT_ZERO: assert property (@(posedge clk) disable iff (rst)
        ((out_sign & out_data) == '0)); // R5
    AST_OUT_COUNT: assert property (@(posedge clk) disable iff (rst)
        (32'(out_nonzero) == $countones(out_sign ^ out_data))); // R6
    AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R7
    AST_VALID_FALL: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R7
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_sign) && $stable(out_data) && $stable(out_nonzero))); // R7
endmodule

// File: tb/test_csd_converter.sv
`timescale 1ns/1ps
module test_csd_converter;
    localparam int W = 16;
    localparam int D = W + 1;
    localparam int CW = $clog2(W + 2);

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic [W-1:0]  in_word;
    logic          out_valid;
    logic [W:0]    out_sign;
    logic [W:0]    out_data;
    logic [CW-1:0] out_nonzero;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    csd_converter #(.WIDTH(W)) i_csd_converter (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
        .out_valid(out_valid), .out_sign(out_sign), .out_data(out_data),
        .out_nonzero(out_nonzero)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Canonical recoding by modular arithmetic: odd remainder r mod 4 picks +1 (r=1) or -1 (r=3).
    task automatic ref_csd(input int v, output logic [W:0] s, output logic [W:0] d, output int w);
        int n = v;
        s = '0; d = '0; w = 0;
        for (int i = 0; i < D; i++) begin
            if (n % 2 == 1) begin
                w++;
                if (n % 4 == 1) begin d[i] = 1'b1; n = n - 1; end
                else begin s[i] = 1'b1; n = n + 1; end
            end
            n = n / 2;
        end
    endtask

    task automatic check_word(input int v);
        logic [W:0] es, ed;
        int ew;
        longint acc = 0;
        int nz = 0;
        bit adj_ok = 1'b1;
        bit code_ok = 1'b1;
        ref_csd(v, es, ed, ew);
        for (int i = 0; i < D; i++) begin
            if (out_data[i] && !out_sign[i]) acc += (longint'(1) << i);
            if (out_sign[i] && !out_data[i]) acc -= (longint'(1) << i);
            if (out_sign[i] ^ out_data[i]) nz++;
            if (out_sign[i] && out_data[i]) code_ok = 1'b0;
            if (i < W && (out_sign[i] ^ out_data[i]) && (out_sign[i+1] ^ out_data[i+1])) adj_ok = 1'b0;
        end
        check(out_valid == 1'b1, "R7 valid", out_valid, 1);
        check(acc == v, "R1 value", acc, v);
        check(adj_ok, "R2 adjacency", v, v);
        check(nz == ew, "R3 minimal weight", nz, ew);
        check(out_sign == es && out_data == ed, "R4 digits", {out_sign, out_data}, {es, ed});
        check(code_ok, "R5 encoding", {out_sign, out_data}, {es, ed});
        check(int'(out_nonzero) == nz, "R6 count", out_nonzero, nz);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_word = 16'hA5A5;
        repeat (3) @(negedge clk);
        // R8 reset state
        check(out_valid == 1'b0, "R8 reset valid", out_valid, 0);
        check(out_sign == '0 && out_data == '0, "R8 reset digits", {out_sign, out_data}, 0);
        check(out_nonzero == '0, "R8 reset count", out_nonzero, 0);
        rst = 1'b0;

        // Exhaustive sweep, one word per cycle; result checked one cycle later.
        for (int v = 0; v <= 65536; v++) begin
            @(negedge clk);
            if (v > 0) check_word(v - 1);
            if (v <= 65535) begin in_valid = 1'b1; in_word = W'(v); end
            else in_valid = 1'b0;
        end

        // R7: idle cycles ignore in_word and hold the last result (0xFFFF).
        in_word = 16'd124;
        @(negedge clk);
        check(out_valid == 1'b0, "R7 idle valid", out_valid, 0);
        check(out_data == 17'h10000 && out_sign == 17'h00001, "R7 hold digits",
              {out_sign, out_data}, {17'h00001, 17'h10000});
        check(out_nonzero == 2, "R7 hold count", out_nonzero, 2);

        // R4 worked examples.
        in_valid = 1'b1; in_word = 16'd124;
        @(negedge clk);
        check(out_data == 17'h80 && out_sign == 17'h4, "R4 example 124",
              {out_sign, out_data}, {17'h4, 17'h80});
        in_word = 16'd123;
        @(negedge clk);
        check(out_data == 17'h80 && out_sign == 17'h5, "R4 example 123",
              {out_sign, out_data}, {17'h5, 17'h80});
        in_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule